// File: doc/BRIEF.md
# Hierarchical Scan Gateway

This block sits behind a boundary-scan test access port. It is a small test data register in its own right, and it can also splice the serial path of one child instrument into the port's scan chain. The block is active only while the port's private gateway-enable instruction is current. In that state, the port's decoded capture, shift and update strobes drive the gateway register. The same strobes pass to the child whenever the child is selected.

The gateway register is three bits wide and follows a capture-shift-update protocol. Bit 0 is the child-enable bit. Bits 2:1 pick how the child is placed in the chain:
- 00 leaves the child out.
- 01 replaces the gateway register with the child.
- 10 places the child between the serial input and the gateway register.
- 11 places the child between the gateway register and the serial output.

The mode is held in a shadow stage that changes only on update. The route therefore never changes while bits are moving. Shift flops sample on the rising test-clock edge, and the serial output is relaunched on the falling edge. An asynchronous active-low test reset clears the shadow stage, which leaves only the gateway register in the chain.

Top module: `scan_gateway`

## Requirements
- R1: While trstN is low, the shadow stage and the shift stage are cleared to 000. Afterwards, childSel is 0, tdo is 0, and the chain holds only the 3-bit gateway register.
- R2: While gwSel is 0, the gateway register does not capture, shift or update. childSel stays 0, and childCapture, childShift and childUpdate stay 0.
- R3: On a rising tck edge with gwSel and captureDr high, the shift stage loads the current shadow value.
- R4: On each rising tck edge with gwSel and shiftDr high, the register moves one place toward bit 0. Bit 0 is the bit that leaves, and the incoming bit enters at bit 2. The captured bits therefore appear at the register's output in the order bit 0, bit 1, bit 2.
- R5: On a rising tck edge with gwSel and updateDr high, the shadow stage takes the shift stage. At no other time do the route or childSel change, except under reset.
- R6: childSel is 1 exactly when gwSel is 1, shadow bit 0 is 1, and shadow bits 2:1 are not 00.
- R7: When shadow bit 0 is 0 or shadow bits 2:1 are 00, the chain is tdi, then the gateway register, then tdo.
- R8: With the child enabled and mode 01, the gateway register is out of the chain and holds its value. tdi drives childTdi, and childTdo drives tdo.
- R9: With the child enabled and mode 10, tdi drives childTdi. childTdo enters the gateway register at bit 2, and register bit 0 drives tdo.
- R10: With the child enabled and mode 11, tdi enters the gateway register. Register bit 0 drives childTdi, and childTdo drives tdo.
- R11: tdo changes only on the falling edge of tck.
- R12: childCapture, childShift and childUpdate each equal childSel ANDed with captureDr, shiftDr and updateDr respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data from the access port |
| gwSel | input | 1 | Gateway-enable instruction is current |
| captureDr | input | 1 | Decoded capture strobe |
| shiftDr | input | 1 | Decoded shift strobe |
| updateDr | input | 1 | Decoded update strobe |
| childTdo | input | 1 | Serial output of the child instrument |
| tdo | output | 1 | Serial data back to the access port |
| childTdi | output | 1 | Serial data forwarded to the child |
| childSel | output | 1 | Local select of the child |
| childCapture | output | 1 | Capture strobe forwarded to the child |
| childShift | output | 1 | Shift strobe forwarded to the child |
| childUpdate | output | 1 | Update strobe forwarded to the child |

## Verification
The assertions check on every cycle that the child select is off without the gateway selected and after reset. They check that the child strobes are silent while the gateway is deselected, and that the child select never moves except across an update edge. The splice routes, the capture and shift order, the falling-edge timing of tdo, and the register being frozen in replace mode can only be shown by the bench's scans. Those scans run through a modelled five-bit child in every mode, and the bench compares the captured bit streams against values worked out from the requirements.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int MODE_W = 2;
  localparam int REG_W  = MODE_W + 1;

  typedef enum logic [MODE_W-1:0] {
    RouteBypass  = 2'b00,
    RouteReplace = 2'b01,
    RouteBefore  = 2'b10,
    RouteAfter   = 2'b11
  } route_e;

  typedef struct packed {
    logic             capLoad;
    logic             shiftEn;
    route_e           route;
    logic [REG_W-1:0] shadow;
  } gw_strobe_t;
endpackage

// File: rtl/gw_ctrl.sv
module gw_ctrl
  import gw_pkg::*;
(
  input  logic             tck,
  input  logic             trstN,
  input  logic             gwSel,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic [REG_W-1:0] capReg,
  output gw_strobe_t       strobe,
  output logic             childSel,
  output logic             childCapture,
  output logic             childShift,
  output logic             childUpdate
);
  logic [REG_W-1:0] shadowQ;
  logic             childOn;
  route_e           route;

  // Shadow stage: the route only moves on an update edge.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                shadowQ <= '0;
    else if (gwSel && updateDr) shadowQ <= capReg;
  end

  assign childOn = shadowQ[0] && (shadowQ[REG_W-1:1] != '0);
  assign route   = childOn ? route_e'(shadowQ[REG_W-1:1]) : RouteBypass;

  always_comb begin
    strobe.capLoad = gwSel && captureDr;
    strobe.shiftEn = gwSel && shiftDr && (route != RouteReplace);
    strobe.route   = route;
    strobe.shadow  = shadowQ;
  end

  assign childSel     = gwSel && childOn;
  assign childCapture = childSel && captureDr;
  assign childShift   = childSel && shiftDr;
  assign childUpdate  = childSel && updateDr;
endmodule

// File: rtl/gw_data.sv
module gw_data
  import gw_pkg::*;
(
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  logic             childTdo,
  input  gw_strobe_t       strobe,
  output logic [REG_W-1:0] capReg,
  output logic             tdo,
  output logic             childTdi
);
  logic [REG_W-1:0] srQ;
  logic             regIn;
  logic             serialOut;
  logic             tdoQ;

  assign regIn = (strobe.route == RouteBefore) ? childTdo : tdi;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              srQ <= '0;
    else if (strobe.capLoad) srQ <= strobe.shadow;
    else if (strobe.shiftEn) srQ <= {regIn, srQ[REG_W-1:1]};
  end

  always_comb begin
    case (strobe.route)
      RouteReplace, RouteAfter: serialOut = childTdo;
      default:                  serialOut = srQ[0];
    endcase
  end

  assign childTdi = (strobe.route == RouteAfter) ? srQ[0] : tdi;

  // Output relaunched half a cycle after the shift edge.
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdoQ <= 1'b0;
    else        tdoQ <= serialOut;
  end

  assign capReg = srQ;
  assign tdo    = tdoQ;
endmodule

// File: rtl/scan_gateway.sv
module scan_gateway
  import gw_pkg::*;
(
  input  logic tck,
  input  logic trstN,
  input  logic tdi,
  input  logic gwSel,
  input  logic captureDr,
  input  logic shiftDr,
  input  logic updateDr,
  input  logic childTdo,
  output logic tdo,
  output logic childTdi,
  output logic childSel,
  output logic childCapture,
  output logic childShift,
  output logic childUpdate
);
  gw_strobe_t       strobe;
  logic [REG_W-1:0] capReg;

  gw_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .gwSel(gwSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .capReg(capReg),
    .strobe(strobe), .childSel(childSel), .childCapture(childCapture),
    .childShift(childShift), .childUpdate(childUpdate)
  );

  gw_data u_data (
    .tck(tck), .trstN(trstN), .tdi(tdi), .childTdo(childTdo),
    .strobe(strobe), .capReg(capReg), .tdo(tdo), .childTdi(childTdi)
  );
endmodule

// File: rtl/gw_checker.sv
module gw_checker (
  input logic tck,
  input logic trstN,
  input logic gwSel,
  input logic updateDr,
  input logic childSel,
  input logic childCapture,
  input logic childShift,
  input logic childUpdate
);
  p_reset_clear_r1: assert property (@(posedge tck) disable iff (!trstN)
    $rose(trstN) |-> !childSel);

  p_quiet_deselect_r2: assert property (@(posedge tck) disable iff (!trstN)
    !gwSel |-> (!childCapture && !childShift && !childUpdate));

  p_route_on_update_r5: assert property (@(posedge tck) disable iff (!trstN)
    (gwSel && $past(gwSel) && !$past(updateDr)) |-> (childSel == $past(childSel)));

  p_sel_needs_gw_r6: assert property (@(posedge tck) disable iff (!trstN)
    childSel |-> gwSel);
endmodule

bind scan_gateway gw_checker u_gwChk (
  .tck(tck), .trstN(trstN), .gwSel(gwSel), .updateDr(updateDr),
  .childSel(childSel), .childCapture(childCapture),
  .childShift(childShift), .childUpdate(childUpdate)
);

// File: tb/scan_gateway_bench.sv
module scan_gateway_bench;
  localparam logic [4:0] CHILD_CAP = 5'b10110;

  logic tck = 1'b0, trstN = 1'b0, tdi = 1'b0, gwSel = 1'b0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic childTdo;
  logic tdo, childTdi, childSel, childCapture, childShift, childUpdate;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 tck = ~tck;

  scan_gateway u_scan_gateway (
    .tck(tck), .trstN(trstN), .tdi(tdi), .gwSel(gwSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .childTdo(childTdo), .tdo(tdo),
    .childTdi(childTdi), .childSel(childSel), .childCapture(childCapture),
    .childShift(childShift), .childUpdate(childUpdate)
  );

  // Child instrument: a five-bit data register living in the bench.
  logic [4:0] childReg = 5'b0;
  always @(posedge tck) begin
    if (childCapture)    childReg <= CHILD_CAP;
    else if (childShift) childReg <= {childTdi, childReg[4:1]};
  end
  assign childTdo = childReg[0];

  // Behavioural reference state.
  logic [2:0] mSr, mSh;
  logic       expTdo;

  function automatic bit mOn();
    return mSh[0] && (mSh[2:1] != 2'b00);
  endfunction
  function automatic int mRoute();
    return mOn() ? int'(mSh[2:1]) : 0;
  endfunction
  function automatic logic mOut();
    int r = mRoute();
    return (r == 1 || r == 3) ? childTdo : mSr[0];
  endfunction

  always @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      mSr <= 3'b000; mSh <= 3'b000;
    end else if (gwSel) begin
      if (captureDr) mSr <= mSh;
      else if (shiftDr && mRoute() != 1)
        mSr <= {(mRoute() == 2) ? childTdo : tdi, mSr[2:1]};
      if (updateDr) mSh <= mSr;
    end
  end

  always @(negedge tck or negedge trstN) begin
    if (!trstN) expTdo <= 1'b0;
    else        expTdo <= mOut();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  logic prevTdo, sampTdo;
  bit   havePrev = 0;

  // One test-clock cycle: drive at posedge+1, check at negedge+1.
  task automatic step(input logic sel, cap, sh, upd, din);
    string tTag;
    int r;
    if (havePrev) chk(tdo === prevTdo, "R11 tdo moved at rising edge", tdo, prevTdo);
    gwSel = sel; captureDr = cap; shiftDr = sh; updateDr = upd; tdi = din;
    @(negedge tck); #1;
    r = mRoute();
    tTag = (r == 1) ? "R8 tdo" : (r == 2) ? "R9 tdo" : (r == 3) ? "R10 tdo" : "R7 tdo";
    chk(tdo === expTdo, tTag, tdo, expTdo);
    chk(childSel === (sel && mOn()), "R6 childSel", childSel, sel && mOn());
    chk(childCapture === (childSel && cap), "R12 childCapture", childCapture, childSel && cap);
    chk(childShift === (childSel && sh), "R12 childShift", childShift, childSel && sh);
    chk(childUpdate === (childSel && upd), "R12 childUpdate", childUpdate, childSel && upd);
    if (childSel) begin
      if (r == 3) chk(childTdi === mSr[0], "R10 childTdi", childTdi, mSr[0]);
      else        chk(childTdi === din, "R9 R8 childTdi", childTdi, din);
    end
    if (!sel) chk(!childSel, "R2 childSel while deselected", childSel, 0);
    sampTdo = tdo; prevTdo = tdo; havePrev = 1;
    @(posedge tck); #1;
  endtask

  // Capture, shift n bits (bit 0 first), update; returns bits seen on tdo.
  task automatic scan(input int n, input logic [7:0] din, output logic [7:0] dout);
    dout = '0;
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 1, 0, din[i]);
      dout[i] = sampTdo;
    end
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] o;
    repeat (2) @(posedge tck);
    #1;
    chk(childSel === 1'b0, "R1 childSel in reset", childSel, 0);
    chk(tdo === 1'b0, "R1 tdo in reset", tdo, 0);
    trstN = 1'b1;
    step(1, 0, 0, 0, 0);

    scan(3, 8'b000, o);
    chk(o[2:0] === 3'b000, "R1 chain after reset", o[2:0], 3'b000);
    chk(childSel === 1'b0, "R7 bypass keeps child off", childSel, 0);
    scan(3, 8'b101, o);
    chk(o[2:0] === 3'b000, "R4 shadow bits out", o[2:0], 3'b000);
    chk(childSel === 1'b1, "R5 select after update", childSel, 1);

    // Mode 10: tdi -> child -> register -> tdo
    scan(8, 8'b0000_0111, o);
    chk(o === 8'b10110101, "R3 R9 before-parent stream", o, 8'b10110101);

    // Mode 11: tdi -> register -> child -> tdo
    scan(8, 8'b0110_0000, o);
    chk(o === 8'b11110110, "R4 R10 after-parent stream", o, 8'b11110110);

    // Mode 01: register out of chain and frozen
    scan(5, 8'b0001_1111, o);
    chk(o[4:0] === CHILD_CAP, "R8 replace stream", o[4:0], CHILD_CAP);
    scan(5, 8'b0, o);
    chk(o[4:0] === CHILD_CAP, "R8 register held", o[4:0], CHILD_CAP);
    chk(childSel === 1'b1, "R8 still replacing", childSel, 1);

    // Deselected gateway ignores strobes
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1);
    step(0, 0, 0, 1, 0);
    chk(childShift === 1'b0, "R2 no forwarded shift", childShift, 0);
    step(1, 0, 0, 0, 0);
    chk(childSel === 1'b1, "R2 shadow untouched", childSel, 1);

    // Asynchronous reset in mid cycle
    @(negedge tck); #1;
    trstN = 1'b0; havePrev = 0;
    #1;
    chk(childSel === 1'b0, "R1 async clear", childSel, 0);
    @(posedge tck); #1;
    trstN = 1'b1;
    step(1, 0, 0, 0, 0);

    // Enable bit low with non-zero mode, then enable high with mode 00
    scan(3, 8'b100, o);
    chk(childSel === 1'b0, "R7 enable low", childSel, 0);
    scan(3, 8'b001, o);
    chk(o[2:0] === 3'b100, "R7 three-bit chain", o[2:0], 3'b100);
    chk(childSel === 1'b0, "R7 mode 00", childSel, 0);
    scan(3, 8'b000, o);
    chk(o[2:0] === 3'b001, "R3 captured shadow", o[2:0], 3'b001);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule